// File: doc/BRIEF.md
# SDRAM Low-Power Mode Sequencer

This block is controller-side logic that moves a mobile SDRAM into and out of its low-power states. It drives the clock-enable pin and the four command strobes (chip select, row strobe, column strobe, write enable). Requests arrive on a valid/ready port that carries a target opcode. The sequencer checks each request against a shadow copy of the device state. A legal request produces the right clock-enable edge together with the right command. An illegal request is refused with a one-cycle error pulse and nothing is driven for it.

Four entries exist, and the command present on the cycle that clock enable first goes low decides which one takes effect. A no-operation with all banks idle gives power-down. An auto-refresh gives self refresh. The burst-terminate encoding gives deep power-down; with clock enable held high the same encoding would only end a burst. If a read or write is in flight, dropping clock enable gives clock suspend. Every wake raises clock enable with a no-operation on the bus. A wake from self refresh also opens a guarded window of no-operations before the device counts as idle again.

Back-pressure: `req_ready` is low only while the self-refresh exit window runs. A request held with `req_valid` high in that window is not consumed, and it is taken on the first cycle that `req_ready` is high. Every accepted request takes effect on the edge that accepts it, and its outputs appear in the following cycle.

Top module: `lpm_seq`

## Requirements
- R1: After reset, `cke`=1, the bus is command inhibit (`cs_n`,`ras_n`,`cas_n`,`we_n` = 1,1,1,1), `err`=0, `req_ready`=1, `dev_idle`=1 and `dev_state`=0 (active).
- R2: Opcode 0 accepted in the active state with `busy_rw`=0 gives, on the next cycle, `cke`=0 with a no-operation (0,1,1,1) and `dev_state`=1 (power-down).
- R3: Opcode 1 accepted in the active state with `busy_rw`=0 gives, on the next cycle, `cke`=0 with auto-refresh (0,0,0,1) and `dev_state`=2 (self refresh).
- R4: Opcode 2 accepted in the active state with `busy_rw`=0 gives, on the next cycle, `cke`=0 with burst-terminate (0,1,1,0) and `dev_state`=3 (deep power-down).
- R5: Opcode 3 accepted in the active state with `busy_rw`=1 gives, on the next cycle, `cke`=0 with a no-operation and `dev_state`=4 (clock suspend).
- R6: While in states 1 to 4 and no legal wake is accepted, `cke` stays 0 and `dev_idle` stays 0.
- R7: Opcode 4 (wake) accepted in states 1, 3 or 4 gives, on the next cycle, `cke`=1 with a no-operation, `dev_state`=0 and `dev_idle`=1. The cycle after that returns to command inhibit.
- R8: Opcode 4 accepted in state 2 gives `cke`=1 and `dev_state`=5 (exit window) for exactly max(TXSR,2) cycles. A no-operation is driven in each of those cycles, and then `dev_state` becomes 0.
- R9: An illegal request gives `err`=1 for one cycle and leaves `cke` and `dev_state` unchanged. Illegal means: an entry outside state 0; opcode 0, 1 or 2 with `busy_rw`=1; opcode 3 with `busy_rw`=0; a wake in state 0; or opcode 5, 6 or 7.
- R10: `req_ready` is 0 exactly while `dev_state`=5, and a request held during that window is not acted on.
- R11: An entry command is on the bus for exactly the one cycle in which `cke` first reads 0. While `cke` stays low after that, the bus is command inhibit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request can be taken this cycle |
| req_op | input | 3 | 0 power-down, 1 self refresh, 2 deep power-down, 3 clock suspend, 4 wake |
| busy_rw | input | 1 | A read or write burst is in progress |
| cke | output | 1 | SDRAM clock enable |
| cs_n | output | 1 | Chip select, active low |
| ras_n | output | 1 | Row strobe, active low |
| cas_n | output | 1 | Column strobe, active low |
| we_n | output | 1 | Write enable, active low |
| err | output | 1 | One-cycle pulse for a refused request |
| dev_idle | output | 1 | Shadow state is active and available |
| dev_state | output | 3 | Shadow state: 0 active, 1 power-down, 2 self refresh, 3 deep power-down, 4 clock suspend, 5 exit window |

## Verification
The hardest case to reach is a request that arrives during the self-refresh exit window. It needs a self-refresh entry, then a wake, then a still-valid request that lands before the window closes. Random stimulus rarely lines these up. Directed sequences therefore build that chain on purpose, and they keep `req_valid` high through the window on an instance with the default TXSR and on a second instance whose TXSR is below the two-cycle floor. Random traffic then weights wake and illegal opcodes, with `busy_rw` toggling, so that the state/opcode combinations for refusal occur often.

// File: rtl/lpm_pkg.sv
package lpm_pkg;
  localparam int OPW = 3;

  localparam logic [OPW-1:0] OP_PD   = 3'd0;
  localparam logic [OPW-1:0] OP_SR   = 3'd1;
  localparam logic [OPW-1:0] OP_DPD  = 3'd2;
  localparam logic [OPW-1:0] OP_SUSP = 3'd3;
  localparam logic [OPW-1:0] OP_WAKE = 3'd4;

  typedef enum logic [2:0] {
    ST_ACT  = 3'd0,
    ST_PD   = 3'd1,
    ST_SR   = 3'd2,
    ST_DPD  = 3'd3,
    ST_SUSP = 3'd4,
    ST_XSR  = 3'd5
  } lp_st_e;

  // {cs_n, ras_n, cas_n, we_n}
  typedef logic [3:0] bus_cmd_t;
  localparam bus_cmd_t CMD_INH  = 4'b1111;
  localparam bus_cmd_t CMD_NOP  = 4'b0111;
  localparam bus_cmd_t CMD_AREF = 4'b0001;
  localparam bus_cmd_t CMD_BST  = 4'b0110;
endpackage

// File: rtl/lpm_legal.sv
module lpm_legal
  import lpm_pkg::*;
(
  input  lp_st_e         cur_st,
  input  logic [OPW-1:0] op,
  input  logic           busy_rw,
  output logic           legal,
  output lp_st_e         nxt_st,
  output logic           nxt_cke,
  output bus_cmd_t       nxt_cmd
);
  logic idle_ok;
  assign idle_ok = (cur_st == ST_ACT) && !busy_rw;

  always_comb begin
    legal   = 1'b0;
    nxt_st  = cur_st;
    nxt_cke = 1'b0;
    nxt_cmd = CMD_INH;
    unique case (op)
      OP_PD: if (idle_ok) begin
        legal = 1'b1; nxt_st = ST_PD; nxt_cmd = CMD_NOP;
      end
      OP_SR: if (idle_ok) begin
        legal = 1'b1; nxt_st = ST_SR; nxt_cmd = CMD_AREF;
      end
      OP_DPD: if (idle_ok) begin
        legal = 1'b1; nxt_st = ST_DPD; nxt_cmd = CMD_BST;
      end
      OP_SUSP: if (cur_st == ST_ACT && busy_rw) begin
        legal = 1'b1; nxt_st = ST_SUSP; nxt_cmd = CMD_NOP;
      end
      OP_WAKE: begin
        if (cur_st == ST_PD || cur_st == ST_DPD || cur_st == ST_SUSP) begin
          legal = 1'b1; nxt_st = ST_ACT; nxt_cke = 1'b1; nxt_cmd = CMD_NOP;
        end else if (cur_st == ST_SR) begin
          legal = 1'b1; nxt_st = ST_XSR; nxt_cke = 1'b1; nxt_cmd = CMD_NOP;
        end
      end
      default: legal = 1'b0;
    endcase
  end
endmodule

// File: rtl/lpm_exit_timer.sv
module lpm_exit_timer #(
  parameter int WIN = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic load,
  output logic done
);
  localparam int CW = (WIN < 2) ? 1 : $clog2(WIN);
  localparam logic [CW-1:0] START = CW'(WIN - 1);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)             cnt_q <= '0;
    else if (load)          cnt_q <= START;
    else if (cnt_q != '0)   cnt_q <= cnt_q - 1'b1;
  end

  assign done = (cnt_q == '0);
endmodule

// File: rtl/lpm_seq.sv
module lpm_seq
  import lpm_pkg::*;
#(
  parameter int TXSR = 4
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           req_valid,
  output logic           req_ready,
  input  logic [OPW-1:0] req_op,
  input  logic           busy_rw,
  output logic           cke,
  output logic           cs_n,
  output logic           ras_n,
  output logic           cas_n,
  output logic           we_n,
  output logic           err,
  output logic           dev_idle,
  output logic [2:0]     dev_state
);
  localparam int WIN = (TXSR < 2) ? 2 : TXSR;

  lp_st_e   st_q;
  logic     cke_q;
  bus_cmd_t cmd_q;
  logic     err_q;

  logic     legal;
  lp_st_e   nxt_st;
  logic     nxt_cke;
  bus_cmd_t nxt_cmd;
  logic     accept;
  logic     tmr_load;
  logic     tmr_done;

  assign req_ready = (st_q != ST_XSR);
  assign accept    = req_valid && req_ready;
  assign tmr_load  = accept && legal && (nxt_st == ST_XSR);

  lpm_legal u_legal (
    .cur_st  (st_q),
    .op      (req_op),
    .busy_rw (busy_rw),
    .legal   (legal),
    .nxt_st  (nxt_st),
    .nxt_cke (nxt_cke),
    .nxt_cmd (nxt_cmd)
  );

  lpm_exit_timer #(.WIN(WIN)) u_timer (
    .clk   (clk),
    .rst_n (rst_n),
    .load  (tmr_load),
    .done  (tmr_done)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q  <= ST_ACT;
      cke_q <= 1'b1;
      cmd_q <= CMD_INH;
      err_q <= 1'b0;
    end else begin
      err_q <= 1'b0;
      cmd_q <= CMD_INH;
      if (accept && legal) begin
        st_q  <= nxt_st;
        cke_q <= nxt_cke;
        cmd_q <= nxt_cmd;
      end else if (accept) begin
        err_q <= 1'b1;
      end else if (st_q == ST_XSR) begin
        if (tmr_done) st_q <= ST_ACT;
        else          cmd_q <= CMD_NOP;
      end
    end
  end

  assign cke       = cke_q;
  assign {cs_n, ras_n, cas_n, we_n} = cmd_q;
  assign err       = err_q;
  assign dev_idle  = (st_q == ST_ACT);
  assign dev_state = st_q;
endmodule

// File: rtl/lpm_seq_chk.sv
module lpm_seq_chk #(
  parameter int TXSR = 4
) (
  input logic       clk,
  input logic       rst_n,
  input logic       req_valid,
  input logic       req_ready,
  input logic [2:0] req_op,
  input logic       cke,
  input logic       cs_n,
  input logic       ras_n,
  input logic       cas_n,
  input logic       we_n,
  input logic       err,
  input logic [2:0] dev_state
);
  localparam int WIN = (TXSR < 2) ? 2 : TXSR;
  localparam int RW  = $clog2(WIN + 2);

  logic [RW-1:0] xsr_run;
  logic          low_st;
  logic          wake_acc;

  assign low_st   = (dev_state >= 3'd1) && (dev_state <= 3'd4);
  assign wake_acc = req_valid && req_ready && (req_op == 3'd4);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                  xsr_run <= '0;
    else if (dev_state == 3'd5)  xsr_run <= xsr_run + 1'b1;
    else                         xsr_run <= '0;
  end

  p_err_from_req_r9: assert property (@(posedge clk) disable iff (!rst_n)
    err |-> $past(req_valid && req_ready));

  p_err_no_move_r9: assert property (@(posedge clk) disable iff (!rst_n)
    err |-> ($stable(cke) && $stable(dev_state)));

  p_hold_low_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (low_st && !wake_acc) |=> !cke);

  p_entry_cmd_r11: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(cke) |-> !cs_n);

  p_held_inhibit_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (!cke && $past(!cke)) |-> cs_n);

  p_exit_nop_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cke) |-> ({cs_n, ras_n, cas_n, we_n} == 4'b0111));

  p_window_ready_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (dev_state == 3'd5) |-> (!req_ready && cke));

  p_window_max_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (dev_state == 3'd5) |-> (int'(xsr_run) < WIN));

  p_window_len_r8: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(dev_state) == 3'd5 && dev_state != 3'd5) |-> (int'(xsr_run) == WIN));
endmodule

bind lpm_seq lpm_seq_chk #(.TXSR(TXSR)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .req_valid (req_valid),
  .req_ready (req_ready),
  .req_op    (req_op),
  .cke       (cke),
  .cs_n      (cs_n),
  .ras_n     (ras_n),
  .cas_n     (cas_n),
  .we_n      (we_n),
  .err       (err),
  .dev_state (dev_state)
);

// File: tb/lpm_seq_bench.sv
`timescale 1ns/1ps
module lpm_seq_bench;
  localparam int TX_A = 4;
  localparam int TX_B = 1;
  localparam int WATCHDOG = 100000;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req_valid = 1'b0;
  logic [2:0] req_op = 3'd0;
  logic busy_rw = 1'b0;

  logic [1:0] rdy, cke, csn, rasn, casn, wen, er, idl;
  logic [2:0] dst [2];

  int n_checks = 0;
  int n_fail = 0;
  int cyc = 0;
  bit finished = 1'b0;

  always #4 clk = ~clk;

  lpm_seq #(.TXSR(TX_A)) u_lpm_seq (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(rdy[0]),
    .req_op(req_op), .busy_rw(busy_rw), .cke(cke[0]), .cs_n(csn[0]),
    .ras_n(rasn[0]), .cas_n(casn[0]), .we_n(wen[0]), .err(er[0]),
    .dev_idle(idl[0]), .dev_state(dst[0]));

  lpm_seq #(.TXSR(TX_B)) u_lpm_seq_short (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(rdy[1]),
    .req_op(req_op), .busy_rw(busy_rw), .cke(cke[1]), .cs_n(csn[1]),
    .ras_n(rasn[1]), .cas_n(casn[1]), .we_n(wen[1]), .err(er[1]),
    .dev_idle(idl[1]), .dev_state(dst[1]));

  // reference model, one set per instance
  int       m_st [2];
  int       m_cnt[2];
  logic     m_cke[2];
  logic [3:0] m_cmd[2];
  logic     m_err[2];
  string    m_tag[2];

  function automatic int win_of(int i);
    int t;
    t = (i == 0) ? TX_A : TX_B;
    return (t < 2) ? 2 : t;
  endfunction

  function automatic logic [10:0] exp_vec(int i);
    return {m_cke[i], m_cmd[i], m_err[i], (m_st[i] != 5), (m_st[i] == 0), 3'(m_st[i])};
  endfunction

  task automatic model_reset();
    for (int i = 0; i < 2; i++) begin
      m_st[i] = 0; m_cnt[i] = 0; m_cke[i] = 1'b1; m_cmd[i] = 4'b1111;
      m_err[i] = 1'b0; m_tag[i] = "R1";
    end
  endtask

  task automatic model_step(int i, logic v, logic [2:0] op, logic bz);
    bit ok;
    bit acc;
    int was;
    ok = 0; was = m_st[i];
    acc = v && (m_st[i] != 5);
    m_err[i] = 1'b0;
    m_cmd[i] = 4'b1111;
    if (acc) begin
      if (was == 0 && !bz && op <= 3'd2) begin
        ok = 1; m_cke[i] = 1'b0;
        if (op == 0) begin m_st[i] = 1; m_cmd[i] = 4'b0111; m_tag[i] = "R2"; end
        else if (op == 1) begin m_st[i] = 2; m_cmd[i] = 4'b0001; m_tag[i] = "R3"; end
        else begin m_st[i] = 3; m_cmd[i] = 4'b0110; m_tag[i] = "R4"; end
      end else if (was == 0 && bz && op == 3'd3) begin
        ok = 1; m_cke[i] = 1'b0; m_st[i] = 4; m_cmd[i] = 4'b0111; m_tag[i] = "R5";
      end else if (op == 3'd4 && (was == 1 || was == 3 || was == 4)) begin
        ok = 1; m_cke[i] = 1'b1; m_st[i] = 0; m_cmd[i] = 4'b0111; m_tag[i] = "R7";
      end else if (op == 3'd4 && was == 2) begin
        ok = 1; m_cke[i] = 1'b1; m_st[i] = 5; m_cnt[i] = win_of(i);
        m_cmd[i] = 4'b0111; m_tag[i] = "R8";
      end
      if (!ok) begin m_err[i] = 1'b1; m_tag[i] = "R9"; end
    end else if (was == 5) begin
      m_cnt[i] = m_cnt[i] - 1;
      if (m_cnt[i] == 0) m_st[i] = 0;
      else m_cmd[i] = 4'b0111;
      m_tag[i] = v ? "R10" : "R8";
    end else if (was >= 1 && was <= 4) begin
      m_tag[i] = (m_cmd[i] == 4'b1111 && !m_cke[i]) ? "R11" : "R6";
    end else begin
      m_tag[i] = "R1";
    end
  endtask

  function automatic logic [10:0] act_vec(int i);
    return {cke[i], csn[i], rasn[i], casn[i], wen[i], er[i], rdy[i], idl[i], dst[i]};
  endfunction

  task automatic compare();
    for (int i = 0; i < 2; i++) begin
      n_checks++;
      if (act_vec(i) !== exp_vec(i)) begin
        n_fail++;
        $display("FAIL %s inst%0d cyc %0d actual %b expected %b (cke cmd err rdy idle st)",
                 m_tag[i], i, cyc, act_vec(i), exp_vec(i));
      end
    end
  endtask

  // one bench cycle: check outputs, then drive inputs and predict the next state
  task automatic step(logic v, logic [2:0] op, logic bz);
    @(negedge clk);
    compare();
    req_valid = v; req_op = op; busy_rw = bz;
    for (int i = 0; i < 2; i++) model_step(i, v, op, bz);
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  endtask

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > WATCHDOG) begin
      n_fail++;
      $display("FAIL watchdog actual %0d cycles expected < %0d", cyc, WATCHDOG);
      finish_run();
    end
  end

  initial begin
    void'($urandom(32'd2024));
    model_reset();
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1: reset state, then quiet cycles
    step(0, 3'd0, 0);
    step(0, 3'd0, 0);
    // R9: wake while active
    step(1, 3'd4, 0);
    // R2 power-down entry, R6/R11 hold, R9 re-entry refused, R7 wake
    step(1, 3'd0, 0);
    step(0, 3'd0, 0);
    step(1, 3'd1, 0);
    step(0, 3'd0, 0);
    step(1, 3'd4, 0);
    step(0, 3'd0, 0);
    // R3 self refresh, R8/R10 window with request held
    step(1, 3'd1, 0);
    step(0, 3'd0, 0);
    step(1, 3'd4, 0);
    for (int k = 0; k < 6; k++) step(1, 3'd2, 0);
    step(0, 3'd0, 0);
    step(1, 3'd4, 0);
    step(0, 3'd0, 0);
    // R3 self refresh, R8 window without requests
    step(1, 3'd1, 0);
    step(1, 3'd4, 0);
    for (int k = 0; k < 6; k++) step(0, 3'd0, 0);
    // R4 deep power-down
    step(1, 3'd2, 0);
    step(0, 3'd0, 0);
    step(1, 3'd4, 1);
    // R9 entries while busy, R5 clock suspend
    step(1, 3'd0, 1);
    step(1, 3'd2, 1);
    step(1, 3'd3, 1);
    step(0, 3'd0, 1);
    step(1, 3'd3, 1);
    step(1, 3'd4, 1);
    // R9 suspend while idle, reserved opcodes
    step(1, 3'd3, 0);
    step(1, 3'd5, 0);
    step(1, 3'd6, 0);
    step(1, 3'd7, 1);
    step(0, 3'd0, 0);
    // constrained random
    for (int k = 0; k < 5000; k++) begin
      logic v;
      logic [2:0] op;
      logic bz;
      int r;
      v  = ($urandom % 100) < 55;
      r  = $urandom % 100;
      if (r < 40)      op = 3'd4;
      else if (r < 90) op = 3'($urandom % 4);
      else             op = 3'(5 + ($urandom % 3));
      bz = ($urandom % 100) < 30;
      step(v, op, bz);
    end
    @(negedge clk);
    compare();
    finish_run();
  end
endmodule